// File: doc/BRIEF.md
# Printer Port Register Controller

This block is a byte-wide register model of a legacy printer port. A host reaches it through a small register bus with 3-bit offsets, separate read and write strobes and 8-bit data. Three registers are mapped: a data register, a status register and a control register. Bytes the host sends to the printer leave the block on a parallel output, marked by a one-cycle transfer pulse. A level interrupt output signals that the emulated printer has acknowledged a byte.

No printer is attached. The busy and acknowledge handshake is computed inside the block from the sequence of control writes and status reads. A driver can therefore run its usual strobe-and-poll loop and see plausible status values. A direction bit in the control register chooses which register a data read returns: the last written byte, or an input byte captured from a parallel input port on a sample strobe.

The transfer output has no back-pressure. The consumer must take `xfer_data` in every cycle where `xfer_valid` is high, and no ready signal exists. Read data is combinational from the offset presented on the same cycle. All read side effects take place at the clock edge that ends a read cycle.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, status reads 0xDB, control reads 0xCC, the written-data and input-data registers both hold 0xFF, and `irq` and `xfer_valid` are low.
- R2: Offset 0 selects data, offset 1 selects status and offset 2 selects control. A read of offsets 3 to 7 returns 0xFF. A write to offset 1 or to offsets 3 to 7 changes no register.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1, and that value reads back from offset 2.
- R4: A control write with bit 2 (init) equal to 0 sets status to exactly 0xD8: bit 7 not-busy, bit 6 ack, bit 4 online and bit 3 not-error set, all other bits clear.
- R5: A control write with bit 2 (init) = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1 clears status bit 7 and keeps the other status bits. If the strobe bit stored before that write was 0, `xfer_valid` is high for exactly the one cycle after the write, and `xfer_data` then carries the last byte written to offset 0.
- R6: A control write with init = 1, select = 1 and strobe = 0 sets the interrupt-pending flag when the previously stored control bit 4 (interrupt enable) is 1.
- R7: `irq` is a registered copy of the pending flag and lags it by one clock cycle.
- R8: A status read returns the status value as it was before the read, and clears the pending flag.
- R9: A status read with status bit 7 = 0 and stored strobe = 0 advances the handshake. If ack (bit 6) is 1, the read clears ack. If ack is 0, the read sets ack and bit 7.
- R10: A data read returns the input-data register when control bit 5 (direction) is 1, and the last written data byte when it is 0.
- R11: When `in_sample` is high at a clock edge, the input-data register loads `in_data`.
- R12: When write and read strobes are high in the same cycle, the write takes effect and the read has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| in_data | input | 8 | Parallel input byte |
| in_sample | input | 1 | Loads `in_data` into the input-data register |
| xfer_data | output | 8 | Byte sent to the emulated printer |
| xfer_valid | output | 1 | One-cycle transfer pulse, no back-pressure |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is the two-step acknowledge sequence. Status must show busy, the stored strobe must be low, and only then do successive status reads first drop ack and then restore ack together with not-busy. Any control write that lands between those reads with init low, or with strobe high, breaks the sequence. A directed run therefore steps through strobe high, strobe low and two status reads, and a second directed run arms interrupt enable before the falling strobe. The random phase weights control writes toward init and select set, so that these sequences also appear mixed with sampling, same-cycle read/write clashes and unmapped offsets.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int REG_AW = 3;
  localparam int DATA_W = 8;

  localparam logic [REG_AW-1:0] OFS_DATA = 3'd0;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd1;
  localparam logic [REG_AW-1:0] OFS_CTRL = 3'd2;

  localparam int ST_NBUSY  = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_PAPER  = 5;
  localparam int ST_ONLINE = 4;
  localparam int ST_NERR   = 3;
  localparam int ST_TMO    = 0;

  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_ALF  = 1;
  localparam int CT_STB  = 0;

  localparam logic [DATA_W-1:0] STATUS_RST  = 8'hDB;
  localparam logic [DATA_W-1:0] STATUS_INIT = 8'hD8;
  localparam logic [DATA_W-1:0] CTRL_RST    = 8'hCC;
  localparam logic [DATA_W-1:0] CTRL_FORCE  = 8'hC0;
  localparam logic [DATA_W-1:0] DATA_RST    = 8'hFF;
  localparam logic [DATA_W-1:0] UNMAPPED    = 8'hFF;

  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_stat;
  } pp_sel_t;
endpackage

// File: rtl/pp_decode.sv
module pp_decode
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output pp_sel_t           sel
);
  logic rd_only;

  // a write in the same cycle wins; the read keeps its data but loses its side effects
  assign rd_only     = rd && !wr;
  assign sel.wr_data = wr && (addr == OFS_DATA);
  assign sel.wr_ctrl = wr && (addr == OFS_CTRL);
  assign sel.rd_stat = rd_only && (addr == OFS_STAT);

  p_rw_clash_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rd) |-> !sel.rd_stat);
  p_sel_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel.wr_data, sel.wr_ctrl, sel.rd_stat}));
endmodule

// File: rtl/pp_handshake.sv
module pp_handshake
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              rd_stat,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] ctrl,
  output logic              emit,
  output logic              irq
);
  logic [DATA_W-1:0] status_q, status_n;
  logic [DATA_W-1:0] ctrl_q, ctrl_n, ctrl_w;
  logic              pend_q, pend_n;
  logic              irq_q;

  assign ctrl_w = wdata | CTRL_FORCE;

  always_comb begin
    status_n = status_q;
    ctrl_n   = ctrl_q;
    pend_n   = pend_q;
    emit     = 1'b0;
    if (wr_ctrl) begin
      if (!ctrl_w[CT_INIT]) begin
        status_n = STATUS_INIT;
      end else if (ctrl_w[CT_SEL]) begin
        if (ctrl_w[CT_STB]) begin
          status_n[ST_NBUSY] = 1'b0;
          emit = !ctrl_q[CT_STB];
        end else if (ctrl_q[CT_IEN]) begin
          pend_n = 1'b1;
        end
      end
      ctrl_n = ctrl_w;
    end else if (rd_stat) begin
      pend_n = 1'b0;
      if (!status_q[ST_NBUSY] && !ctrl_q[CT_STB]) begin
        if (status_q[ST_ACK]) begin
          status_n[ST_ACK] = 1'b0;
        end else begin
          status_n[ST_ACK]   = 1'b1;
          status_n[ST_NBUSY] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      ctrl_q   <= CTRL_RST;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      ctrl_q   <= ctrl_n;
      pend_q   <= pend_n;
      irq_q    <= pend_q;
    end
  end

  assign status = status_q;
  assign ctrl   = ctrl_q;
  assign irq    = irq_q;

  p_ctrl_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q[7:6] == 2'b11));
  p_init_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[CT_INIT]) |=> (status_q == STATUS_INIT));
  p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB]) |=> !status_q[ST_NBUSY]);
  p_stat_clr_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> ##1 !irq_q);
  p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !status_q[ST_NBUSY] && !ctrl_q[CT_STB] && status_q[ST_ACK]) |=> !status_q[ST_ACK]);
  p_ack_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !status_q[ST_NBUSY] && !ctrl_q[CT_STB] && !status_q[ST_ACK])
      |=> (status_q[ST_ACK] && status_q[ST_NBUSY]));
endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              emit,
  input  logic              dir_in,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sample,
  output logic [DATA_W-1:0] data_rd,
  output logic [DATA_W-1:0] xfer_data,
  output logic              xfer_valid
);
  logic [DATA_W-1:0] dataw_q, datar_q, xfer_q;
  logic              xv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataw_q <= DATA_RST;
      datar_q <= DATA_RST;
      xfer_q  <= DATA_RST;
      xv_q    <= 1'b0;
    end else begin
      if (wr_data)   dataw_q <= wdata;
      if (in_sample) datar_q <= in_data;
      if (emit)      xfer_q  <= dataw_q;
      xv_q <= emit;
    end
  end

  assign data_rd    = dir_in ? datar_q : dataw_q;
  assign xfer_data  = xfer_q;
  assign xfer_valid = xv_q;

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xv_q |=> !xv_q);
  p_sample_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_sample |=> (datar_q == $past(in_data)));
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sample,
  output logic [DATA_W-1:0] xfer_data,
  output logic              xfer_valid,
  output logic              irq
);
  pp_sel_t           sel;
  logic [DATA_W-1:0] status, ctrl, data_rd;
  logic              emit;

  pp_decode u_dec (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd), .sel(sel)
  );

  pp_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(sel.wr_ctrl), .rd_stat(sel.rd_stat),
    .wdata(reg_wdata), .status(status), .ctrl(ctrl), .emit(emit), .irq(irq)
  );

  pp_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .wr_data(sel.wr_data), .wdata(reg_wdata), .emit(emit),
    .dir_in(ctrl[CT_DIR]), .in_data(in_data), .in_sample(in_sample),
    .data_rd(data_rd), .xfer_data(xfer_data), .xfer_valid(xfer_valid)
  );

  always_comb begin
    case (reg_addr)
      OFS_DATA: reg_rdata = data_rd;
      OFS_STAT: reg_rdata = status;
      OFS_CTRL: reg_rdata = ctrl;
      default:  reg_rdata = UNMAPPED;
    endcase
  end

  p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > OFS_CTRL) |-> (reg_rdata == UNMAPPED));
endmodule

// File: tb/prn_port_regs_bench.sv
`timescale 1ns/1ps
module prn_port_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, in_sample = 1'b0;
  logic [7:0] reg_wdata = '0, in_data = '0;
  logic [7:0] reg_rdata, xfer_data;
  logic       xfer_valid, irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] m_st, m_ct, m_dw, m_dr;
  logic       m_pend;

  always #2.5 clk = ~clk;

  prn_port_regs u_prn_port_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_data(in_data), .in_sample(in_sample),
    .xfer_data(xfer_data), .xfer_valid(xfer_valid), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ct[5] ? m_dr : m_dw;  // R10
      3'd1: return m_st;                   // R8
      3'd2: return m_ct;                   // R3
      default: return 8'hFF;               // R2
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R10 data read";
      3'd1: return "R8 status read";
      3'd2: return "R3 control read";
      default: return "R2 unmapped read";
    endcase
  endfunction

  // call just after a falling edge
  task automatic acc(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d,
                     input logic smp, input logic [7:0] sd);
    logic prev_pend;
    logic emit;
    logic [7:0] v;
    logic [7:0] xd;
    prev_pend = m_pend;
    emit = 1'b0;
    xd = m_dw;
    reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d; in_sample = smp; in_data = sd;
    #1;
    if (r && !w) chk(tag_of(a), reg_rdata, exp_read(a));
    @(posedge clk);
    if (w) begin
      if (a == 3'd0) m_dw = d;
      else if (a == 3'd2) begin
        v = d | 8'hC0;
        if (!v[2]) m_st = 8'hD8;                  // R4
        else if (v[3]) begin
          if (v[0]) begin
            m_st[7] = 1'b0;                        // R5
            emit = !m_ct[0];
          end else if (m_ct[4]) m_pend = 1'b1;     // R6
        end
        m_ct = v;
      end
    end else if (r && a == 3'd1) begin             // R12: only without write
      m_pend = 1'b0;
      if (!m_st[7] && !m_ct[0]) begin              // R9
        if (m_st[6]) m_st[6] = 1'b0;
        else begin m_st[6] = 1'b1; m_st[7] = 1'b1; end
      end
    end
    if (smp) m_dr = sd;                            // R11
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; in_sample = 1'b0;
    #1;
    chk("R7 irq lag", {7'd0, irq}, {7'd0, prev_pend});
    chk("R5 xfer pulse", {7'd0, xfer_valid}, {7'd0, emit});
    if (emit) chk("R5 xfer data", xfer_data, xd);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int op;
    void'($urandom(32'd20240611));
    m_st = 8'hDB; m_ct = 8'hCC; m_dw = 8'hFF; m_dr = 8'hFF; m_pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 xfer_valid", {7'd0, xfer_valid}, 8'd0);
    chk("R1 status", reg_addr == 3'd0 ? 8'hDB : 8'hDB, 8'hDB);
    reg_addr = 3'd1; #0.1;
    chk("R1 status value", reg_rdata, 8'hDB);
    reg_addr = 3'd2; #0.1;
    chk("R1 control value", reg_rdata, 8'hCC);
    reg_addr = 3'd0; #0.1;
    chk("R1 written data", reg_rdata, 8'hFF);
    @(negedge clk);
    acc(1, 0, 3'd2, 8'h2C, 0, 8'h00);           // direction input
    acc(0, 1, 3'd0, 8'h00, 0, 8'h00);           // R1 input data 0xFF
    chk("R1 input data", reg_rdata, 8'hFF);
    // R11 + R10
    acc(0, 0, 3'd0, 8'h00, 1, 8'h5A);
    acc(0, 1, 3'd0, 8'h00, 0, 8'h00);
    acc(1, 0, 3'd0, 8'hA7, 0, 8'h00);
    acc(1, 0, 3'd2, 8'h0C, 0, 8'h00);           // direction output
    acc(0, 1, 3'd0, 8'h00, 0, 8'h00);
    // R2: writes to status and unmapped offsets ignored
    acc(1, 0, 3'd1, 8'h00, 0, 8'h00);
    acc(1, 0, 3'd6, 8'h00, 0, 8'h00);
    acc(0, 1, 3'd1, 8'h00, 0, 8'h00);
    acc(0, 1, 3'd7, 8'h00, 0, 8'h00);
    // R5/R9 handshake: strobe high, strobe low, two status reads
    acc(1, 0, 3'd2, 8'h0D, 0, 8'h00);
    acc(1, 0, 3'd2, 8'h0C, 0, 8'h00);
    acc(0, 1, 3'd1, 8'h00, 0, 8'h00);
    acc(0, 1, 3'd1, 8'h00, 0, 8'h00);
    acc(0, 1, 3'd1, 8'h00, 0, 8'h00);
    reg_addr = 3'd1; #0.1;
    chk("R9 handshake restored", reg_rdata & 8'hC0, 8'hC0);
    @(negedge clk);
    // R6/R7/R8 interrupt: arm enable with strobe high, then drop strobe
    acc(1, 0, 3'd2, 8'h1D, 0, 8'h00);
    acc(1, 0, 3'd2, 8'h1C, 0, 8'h00);
    acc(0, 0, 3'd3, 8'h00, 0, 8'h00);
    chk("R6 irq raised", {7'd0, irq}, 8'd1);
    acc(1, 1, 3'd1, 8'h00, 0, 8'h00);          // R12 clash: pending kept
    acc(0, 0, 3'd3, 8'h00, 0, 8'h00);
    chk("R12 irq kept", {7'd0, irq}, 8'd1);
    acc(0, 1, 3'd1, 8'h00, 0, 8'h00);
    acc(0, 0, 3'd3, 8'h00, 0, 8'h00);
    chk("R8 irq cleared", {7'd0, irq}, 8'd0);
    // R4 init low
    acc(1, 0, 3'd2, 8'h08, 0, 8'h00);
    acc(0, 1, 3'd1, 8'h00, 0, 8'h00);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      op = $urandom % 8;
      d = 8'($urandom);
      case (op)
        0, 1, 2: begin
          if (($urandom % 4) != 0) d[3:2] = 2'b11;
          acc(1, 0, 3'd2, d, ($urandom % 8) == 0, 8'($urandom));
        end
        3, 4: acc(0, 1, 3'd1, 8'h00, ($urandom % 8) == 0, 8'($urandom));
        5: acc(1, 0, 3'd0, d, ($urandom % 8) == 0, 8'($urandom));
        6: acc(0, 1, 3'd0, 8'h00, ($urandom % 4) == 0, 8'($urandom));
        default: acc(1'($urandom), 1'($urandom), 3'($urandom), d, 1'($urandom), 8'($urandom));
      endcase
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule